// File: doc/BRIEF.md
# Single-Rounding Signed Multiply-Accumulate

This block multiplies a signed sample by a signed coefficient on every valid cycle and adds the result into a running accumulator. The multiplier recodes the coefficient in radix-4 Booth digits. It compresses the partial products in carry-save form and does not resolve them. The resulting sum and carry words go straight into the accumulate stage. A single carry-propagate adder there combines them with the fed-back accumulator.

Precision is dropped at exactly one point in the loop. A rounding constant of half an LSB at the rounding position enters the carry-save tree as an extra row. The fed-back accumulator is truncated by that same number of bits and padded with zeros on the right, so the truncation happens only at that point. A clear strobe restarts accumulation: the next valid sample sees a zero feedback. If the strobe arrives on an idle cycle, the clear is held until the next valid sample. The accumulator wraps modulo its width and has no saturation.

Top module: `mac_single_round`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows acc_out = 0 and out_valid = 0.
- R2: out_valid is high in the cycle after each cycle with in_valid high, and low in the cycle after each cycle with in_valid low.
- R3: The product of data_in and coef_in is formed as two's-complement 13 x 13 bits (a 26-bit signed product) using radix-4 Booth digits. It is held as a sum word and a carry word whose modular sum equals the sign-extended product plus the rounding constant 4.
- R4: On a valid cycle without an effective clear, the next acc_out equals (product + 4 + the previous acc_out with its low 3 bits forced to zero) modulo 2^28.
- R5: On a valid cycle with clr high, the feedback is zero and the next acc_out equals the sign-extended product + 4.
- R6: A clr pulse on a cycle with in_valid low leaves acc_out unchanged and makes the next valid sample behave as in R5.
- R7: On a cycle with in_valid low, acc_out keeps its value.
- R8: The low 3 bits of acc_out after a valid sample equal the low 3 bits of (product + 4). Bits of the earlier accumulator below the rounding position never reach the result.
- R9: The accumulator wraps modulo 2^28 with no saturation, including the extreme product (-4096) x (-4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Clear strobe: next valid sample starts from zero feedback |
| in_valid | input | 1 | Qualifies data_in and coef_in |
| data_in | input | 13 | Signed sample |
| coef_in | input | 13 | Signed coefficient |
| acc_out | output | 28 | Registered accumulator |
| out_valid | output | 1 | High one cycle after each valid input |

## Verification
A wrong Booth digit or a dropped carry-save row shows up as a wrong acc_out one cycle after the sample, because the accumulator register is the only state between the inputs and the port. A faulty rounding or truncation point appears first in the low three bits, and a misplaced feedback truncation appears in those bits and above them on the following sample. A lost or stuck pending clear appears at the first valid sample after the idle strobe, as an accumulator that did not restart. A hold fault shows as acc_out changing on an idle cycle.

// File: rtl/mac_pkg.sv
// Package: shared Booth digit type and encoder for the multiply-accumulate.
// Assumes radix-4 recoding over overlapping bit triplets of the multiplier.
package mac_pkg;

    // One radix-4 digit: magnitude select (one or two) and sign.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_sel_t;

    // Decode a multiplier triplet {b(2i+1), b(2i), b(2i-1)} into a digit.
    function automatic booth_sel_t booth_encode(input logic [2:0] trip);
        booth_sel_t sel;
        sel.neg = trip[2];
        sel.one = trip[1] ^ trip[0];
        sel.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
        return sel;
    endfunction

endpackage

// File: rtl/mac_booth_pp.sv
// Booth partial-product generator.
// Produces one shifted row per radix-4 digit of the multiplier. A negative
// digit yields the inverted magnitude, and its +1 correction is collected
// in a separate last row. All rows are sign-extended to OUT_W bits.
// Assumes OUT_W >= 2*IN_W + 1 so that no row overflows.
module mac_booth_pp
    import mac_pkg::*;
#(
    parameter int IN_W  = 13,
    parameter int OUT_W = 28,
    localparam int NPP  = (IN_W + 2) / 2,
    localparam int YW   = 2 * NPP + 1
) (
    input  logic [IN_W-1:0]            mcand,
    input  logic [IN_W-1:0]            mplr,
    output logic [NPP:0][OUT_W-1:0]    rows
);

    logic [YW-1:0]       y_ext;
    logic [OUT_W-1:0]    x_ext;
    booth_sel_t          sel [NPP];
    logic [OUT_W-1:0]    pp  [NPP];
    logic [OUT_W-1:0]    neg_word;

    // Purpose: sign-extend the multiplier with a zero appended below bit 0.
    assign y_ext = {{(YW - 1 - IN_W){mplr[IN_W-1]}}, mplr, 1'b0};
    // Purpose: sign-extend the multiplicand to row width.
    assign x_ext = {{(OUT_W - IN_W){mcand[IN_W-1]}}, mcand};

    for (genvar i = 0; i < NPP; i++) begin : g_digit
        logic [OUT_W-1:0] mag;
        logic [OUT_W-1:0] signed_mag;

        // Purpose: recode the overlapping triplet into a digit select.
        assign sel[i] = booth_encode(y_ext[2*i+2 : 2*i]);

        // Purpose: pick the multiplicand magnitude for this digit.
        always_comb begin
            if (sel[i].one)
                mag = x_ext;
            else if (sel[i].two)
                mag = x_ext << 1;
            else
                mag = '0;
        end

        // Purpose: invert for a negative digit; the +1 goes to neg_word.
        assign signed_mag = sel[i].neg ? ~mag : mag;
        assign pp[i]      = signed_mag << (2 * i);
    end

    // Purpose: collect the two's-complement +1 of every negative digit.
    always_comb begin
        neg_word = '0;
        for (int i = 0; i < NPP; i++) begin
            neg_word[2*i] = sel[i].neg;
        end
    end

    // Purpose: pack the partial products and the correction row.
    always_comb begin
        for (int i = 0; i < NPP; i++) begin
            rows[i] = pp[i];
        end
        rows[NPP] = neg_word;
    end

endmodule

// File: rtl/mac_csa_tree.sv
// Carry-save reducer.
// Folds NIN rows into one sum word and one carry word with a chain of 3:2
// compressors. Nothing is propagated, so the result is redundant: the two
// words add modulo 2^W to the sum of the input rows.
// Assumes NIN >= 3.
module mac_csa_tree #(
    parameter int W   = 28,
    parameter int NIN = 9
) (
    input  logic [NIN-1:0][W-1:0] rows,
    output logic [W-1:0]          sum_o,
    output logic [W-1:0]          carry_o
);

    logic [W-1:0] s_st [NIN-1];
    logic [W-1:0] c_st [NIN-1];

    // Purpose: the first two rows seed the chain unchanged.
    assign s_st[0] = rows[0];
    assign c_st[0] = rows[1];

    for (genvar j = 1; j < NIN - 1; j++) begin : g_level
        logic [W-1:0] nxt;
        logic [W-1:0] maj;
        // Purpose: compress the running pair and one new row, 3 to 2.
        assign nxt     = rows[j+1];
        assign s_st[j] = s_st[j-1] ^ c_st[j-1] ^ nxt;
        assign maj     = (s_st[j-1] & c_st[j-1]) | (s_st[j-1] & nxt) | (c_st[j-1] & nxt);
        assign c_st[j] = maj << 1;
    end

    assign sum_o   = s_st[NIN-2];
    assign carry_o = c_st[NIN-2];

endmodule

// File: rtl/mac_accum.sv
// Accumulate stage.
// Adds the carry-save product words to the fed-back accumulator, whose low
// RND_BITS bits are replaced by zeros, in one unpipelined adder. It holds the
// accumulator on idle cycles and remembers a clear strobe seen while idle.
// Assumes the rounding constant is already inside the carry-save words.
module mac_accum #(
    parameter int ACC_W    = 28,
    parameter int RND_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             clr,
    input  logic [ACC_W-1:0] ps_sum,
    input  logic [ACC_W-1:0] ps_carry,
    output logic [ACC_W-1:0] acc_q,
    output logic             valid_q
);

    logic             clr_pend_q;
    logic             clear_eff;
    logic [ACC_W-1:0] feedback;
    logic [ACC_W-1:0] f_sum;
    logic [ACC_W-1:0] f_carry;
    logic [ACC_W-1:0] acc_d;

    // Purpose: a clear applies now or was held from an idle cycle.
    assign clear_eff = clr | clr_pend_q;

    // Purpose: truncated, zero-padded feedback, or zero after a clear.
    assign feedback = clear_eff ? '0 : {acc_q[ACC_W-1:RND_BITS], {RND_BITS{1'b0}}};

    // Purpose: merge the three operands to two before the one final adder.
    always_comb begin
        f_sum   = ps_sum ^ ps_carry ^ feedback;
        f_carry = ((ps_sum & ps_carry) | (ps_sum & feedback) | (ps_carry & feedback)) << 1;
        acc_d   = f_sum + f_carry;
    end

    // Purpose: accumulator, output flag and held-clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            valid_q    <= 1'b0;
            clr_pend_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                acc_q      <= acc_d;
                clr_pend_q <= 1'b0;
            end else if (clr) begin
                clr_pend_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mac_single_round.sv
// Single-rounding multiply-accumulate, top level.
// Booth rows, the correction row and a half-LSB rounding row are reduced to
// carry-save form at accumulator width and handed to the accumulate stage.
// Assumes ACC_W >= 2*IN_W + 1 and RND_BITS >= 1.
module mac_single_round #(
    parameter int IN_W     = 13,
    parameter int ACC_W    = 28,
    parameter int RND_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  data_in,
    input  logic [IN_W-1:0]  coef_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             out_valid
);

    localparam int NPP  = (IN_W + 2) / 2;
    localparam int NROW = NPP + 2;
    localparam logic [ACC_W-1:0] RND_K = ACC_W'(1) << (RND_BITS - 1);

    logic [NPP:0][ACC_W-1:0]    booth_rows;
    logic [NROW-1:0][ACC_W-1:0] all_rows;
    logic [ACC_W-1:0]           pp_sum;
    logic [ACC_W-1:0]           pp_carry;

    mac_booth_pp #(
        .IN_W  (IN_W),
        .OUT_W (ACC_W)
    ) u_booth (
        .mcand (data_in),
        .mplr  (coef_in),
        .rows  (booth_rows)
    );

    // Purpose: append the single rounding constant as the last row.
    always_comb begin
        for (int i = 0; i <= NPP; i++) begin
            all_rows[i] = booth_rows[i];
        end
        all_rows[NROW-1] = RND_K;
    end

    mac_csa_tree #(
        .W   (ACC_W),
        .NIN (NROW)
    ) u_csa (
        .rows    (all_rows),
        .sum_o   (pp_sum),
        .carry_o (pp_carry)
    );

    mac_accum #(
        .ACC_W    (ACC_W),
        .RND_BITS (RND_BITS)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .clr      (clr),
        .ps_sum   (pp_sum),
        .ps_carry (pp_carry),
        .acc_q    (acc_out),
        .valid_q  (out_valid)
    );

endmodule

// File: rtl/mac_single_round_chk.sv
// Checker for mac_single_round, attached by bind. It compares the carry-save
// words and the ports with a plain product computed here.
module mac_single_round_chk #(
    parameter int IN_W     = 13,
    parameter int ACC_W    = 28,
    parameter int RND_BITS = 3,
    localparam int PROD_W  = 2 * IN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_valid,
    input logic [IN_W-1:0]  data_in,
    input logic [IN_W-1:0]  coef_in,
    input logic [ACC_W-1:0] pp_sum,
    input logic [ACC_W-1:0] pp_carry,
    input logic [ACC_W-1:0] acc_out,
    input logic             out_valid
);

    logic signed [PROD_W-1:0] prod_c;
    logic [ACC_W-1:0]         lead_exp;
    logic [ACC_W-1:0]         cs_total;

    assign prod_c   = $signed(data_in) * $signed(coef_in);
    assign lead_exp = {{(ACC_W - PROD_W){prod_c[PROD_W-1]}}, prod_c} + (ACC_W'(1) << (RND_BITS - 1));
    assign cs_total = pp_sum + pp_carry;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && !out_valid));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r3_carry_save_value: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> cs_total == lead_exp);

    a_r5_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clr) |=> acc_out == $past(lead_exp));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_out));

    a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> acc_out[RND_BITS-1:0] == $past(lead_exp[RND_BITS-1:0]));

endmodule

bind mac_single_round mac_single_round_chk #(
    .IN_W     (IN_W),
    .ACC_W    (ACC_W),
    .RND_BITS (RND_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .data_in   (data_in),
    .coef_in   (coef_in),
    .pp_sum    (pp_sum),
    .pp_carry  (pp_carry),
    .acc_out   (acc_out),
    .out_valid (out_valid)
);

// File: tb/tb_mac_single_round.sv
module tb_mac_single_round;

    localparam int  IN_W     = 13;
    localparam int  ACC_W    = 28;
    localparam int  RND_BITS = 3;
    localparam time CLK_PER  = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  data_in = '0;
    logic [IN_W-1:0]  coef_in = '0;
    logic [ACC_W-1:0] acc_out;
    logic             out_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [ACC_W-1:0] exp_acc  = '0;
    bit               exp_pend = 1'b0;

    mac_single_round #(
        .IN_W     (IN_W),
        .ACC_W    (ACC_W),
        .RND_BITS (RND_BITS)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (in_valid),
        .data_in   (data_in),
        .coef_in   (coef_in),
        .acc_out   (acc_out),
        .out_valid (out_valid)
    );

    always #(CLK_PER / 2) clk = ~clk;

    // Reference: product + half LSB + zero-padded truncated feedback.
    function automatic logic [ACC_W-1:0] model_next(input logic [ACC_W-1:0] acc,
                                                   input logic [IN_W-1:0] d,
                                                   input logic [IN_W-1:0] c,
                                                   input bit clear);
        logic signed [2*IN_W-1:0] p;
        logic [ACC_W-1:0]         px;
        logic [ACC_W-1:0]         fb;
        p  = $signed(d) * $signed(c);
        px = {{(ACC_W - 2*IN_W){p[2*IN_W-1]}}, p};
        fb = clear ? '0 : {acc[ACC_W-1:RND_BITS], {RND_BITS{1'b0}}};
        return px + (ACC_W'(1) << (RND_BITS - 1)) + fb;
    endfunction

    task automatic check(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Drive one cycle at the falling edge, then check after the next rising edge.
    task automatic step(input bit v, input bit cl, input logic [IN_W-1:0] d,
                        input logic [IN_W-1:0] c, input string tag);
        bit clear_eff;
        in_valid = v;
        clr      = cl;
        data_in  = d;
        coef_in  = c;
        clear_eff = cl | exp_pend;
        if (v) begin
            exp_acc  = model_next(exp_acc, d, c, clear_eff);
            exp_pend = 1'b0;
        end else if (cl) begin
            exp_pend = 1'b1;
        end
        @(negedge clk);
        check(tag, acc_out, exp_acc);
        check("R2 out_valid", ACC_W'(out_valid), ACC_W'(v));
        if (v) begin
            logic [ACC_W-1:0] low_exp;
            low_exp = model_next('0, d, c, 1'b1);
            check("R8 low bits", ACC_W'(acc_out[RND_BITS-1:0]), ACC_W'(low_exp[RND_BITS-1:0]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);

        // R1: reset state, with junk on the inputs during reset.
        @(negedge clk);
        in_valid = 1'b1;
        data_in  = 13'h0abc;
        coef_in  = 13'h1123;
        @(negedge clk);
        @(negedge clk);
        check("R1 acc_out", acc_out, '0);
        check("R1 out_valid", ACC_W'(out_valid), '0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        exp_acc  = '0;
        exp_pend = 1'b0;

        // R3: product corners, each restarted with a clear (R5).
        step(1, 1, 13'h1000, 13'h1000, "R3 min x min");
        step(1, 1, 13'h1000, 13'h0fff, "R3 min x max");
        step(1, 1, 13'h0fff, 13'h0fff, "R3 max x max");
        step(1, 1, 13'h1fff, 13'h0001, "R3 -1 x 1");
        step(1, 1, 13'h0000, 13'h1555, "R3 zero data");
        step(1, 1, 13'h0a5a, 13'h0000, "R5 zero coef");

        // R4: plain accumulation from a known start.
        step(1, 0, 13'h0123, 13'h1f37, "R4 acc a");
        step(1, 0, 13'h1ee1, 13'h0777, "R4 acc b");

        // R7: idle cycles hold.
        step(0, 0, 13'h1abc, 13'h0def, "R7 hold a");
        step(0, 0, 13'h0001, 13'h0001, "R7 hold b");

        // R6: clear on an idle cycle is held until the next valid sample.
        step(0, 1, 13'h0333, 13'h0444, "R6 idle clear keeps acc");
        step(0, 0, 13'h0333, 13'h0444, "R6 pending idle");
        step(1, 0, 13'h0011, 13'h1ff3, "R6 pending clear applied");
        step(1, 0, 13'h0011, 13'h1ff3, "R6 after clear accumulates");

        // R9: wrap by repeated extreme products.
        step(1, 1, 13'h1000, 13'h1000, "R9 start");
        for (int k = 0; k < 14; k++) begin
            step(1, 0, 13'h1000, 13'h1000, "R9 wrap");
        end

        // Random mix: valid, idle, and clear strobes.
        for (int k = 0; k < 600; k++) begin
            bit v;
            bit cl;
            logic [IN_W-1:0] d;
            logic [IN_W-1:0] c;
            string tag;
            v  = ($urandom % 4) != 0;
            cl = ($urandom % 10) == 0;
            d  = IN_W'($urandom);
            c  = IN_W'($urandom);
            if (v && (cl || exp_pend)) tag = "R5 random clear";
            else if (v)                tag = "R4 random acc";
            else if (cl)               tag = "R6 random idle clear";
            else                       tag = "R7 random idle";
            step(v, cl, d, c, tag);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule